// File: doc/BRIEF.md
# Ternary Content Addressable Memory

This block is a ternary lookup table. Each row holds a key in which every bit position is a one, a zero or a wildcard. A caller loads rows one at a time through a write port. A search presents a key and gets back three results one cycle later: a vector with one bit per row that marks every matching row, the index of the matching row with the lowest number, and a flag that says whether any row matched.

Each ternary position is kept as two storage planes, called high and low. The pair high=1/low=0 stores a one, high=0/low=1 stores a zero, and 0/0 is a wildcard that takes no part in the comparison. The pair 1/1 can only be loaded through a raw write. It never matches, so it fences off the whole row. A power-down input stops match evaluation. A scan path lets a tester shift the search key in serially and shift every result bit out serially.

Searches use a valid/ready handshake with back-pressure. A search is accepted on a clock edge where `srch_valid` and `srch_ready` are both high. A result moves out on an edge where `res_valid` and `res_ready` are both high. There is a single result register, so `srch_ready` is high only when that register is empty or is being drained in the same cycle. A result that is waiting stays unchanged until it is taken. Write, power-down and test pins are plain level controls.

Top module: `tcam_array`

## Requirements
- R1: A normal write (`wr_raw`=0) stores every bit position as follows. With care=1 and value=1 the pair is high=1/low=0 and matches only a key bit of 1. With care=1 and value=0 the pair is high=0/low=1 and matches only a key bit of 0. With care=0 the pair is 0/0, a wildcard that never causes a mismatch.
- R2: A raw write (`wr_raw`=1) puts `wr_val` into the high plane and `wr_care` into the low plane unchanged. A row with any position holding 1/1 never matches, whatever the key.
- R3: An accepted search makes `res_valid` high on the next cycle. Bit r of `res_match` is 1 exactly when row r has been written since reset and every one of its positions matches the key.
- R4: `res_hit` is 1 exactly when `res_match` has at least one bit set.
- R5: `res_idx` is the lowest row number whose `res_match` bit is set. It is 0 when no row matches.
- R6: A search accepted while `pdn`=1 returns an all-zero match vector, `res_hit`=0 and `res_idx`=0. Stored rows are kept, so a later search with `pdn`=0 returns the same result as before power-down.
- R7: After reset no row matches, not even for rows whose contents would match the key, until that row is written.
- R8: A search accepted on the same edge as a write to a row compares against that row's contents from before the write.
- R9: `srch_ready` = !`res_valid` || `res_ready`. While `res_valid`=1 and `res_ready`=0, the result outputs and `res_valid` stay unchanged.
- R10: With `tst_mode`=1, searches use the scan key register and ignore `srch_key`. Each `tst_shift` cycle moves `tst_si` into bit 0 and moves every other bit up by one, so the first bit shifted in ends up in the MSB after KEY_W shifts.
- R11: `tst_capture` loads the output chain with {`res_hit`, `res_idx`, `res_match`}. `tst_so` shows the MSB of the chain. Each shift moves the next bit to `tst_so`, so the bits come out in this order: the hit flag, then the index MSB first, then `res_match` from the top row down to row 0.
- R12: After reset `res_valid`=0 and `srch_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one row this cycle |
| wr_raw | input | 1 | 1: value/care load the high/low planes directly |
| wr_addr | input | IDX_W | Row to write |
| wr_val | input | KEY_W | Value bits (or high plane when raw) |
| wr_care | input | KEY_W | Care mask (or low plane when raw) |
| srch_valid | input | 1 | Search request present |
| srch_ready | output | 1 | Search can be accepted |
| srch_key | input | KEY_W | Search key (functional mode) |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_match | output | ROWS | One match bit per row |
| res_idx | output | IDX_W | Lowest matching row |
| res_hit | output | 1 | Any row matched |
| pdn | input | 1 | Power-down: match evaluation off |
| tst_mode | input | 1 | Search key taken from scan register |
| tst_shift | input | 1 | Shift both scan chains |
| tst_capture | input | 1 | Load output chain from results |
| tst_si | input | 1 | Scan data in |
| tst_so | output | 1 | Scan data out |

## Verification
The hardest case to set up from the ports is a row that holds the 1/1 pair. A normal write can never produce it, so the bench uses a raw write to put 1/1 in one position of a row that was a full wildcard and matched everything. It then checks that this row drops out of the match vector and that the hit index moves to the next matching row. Two other cases depend on exact timing. In the first, a write and a search land on the same edge, and the expected result is built from the model state before that edge. In the second, a search is kept waiting behind a stalled result, so the bench checks that the waiting result stays frozen and that both results then come out in order. The scan path is covered by shifting a key in while `res_ready` is held low, capturing the result, and comparing all shifted-out bits with the model.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  // Cell pair {high, low}
  typedef enum logic [1:0] {
    CELL_WILD  = 2'b00,
    CELL_ZERO  = 2'b01,
    CELL_ONE   = 2'b10,
    CELL_NEVER = 2'b11
  } cell_pair_e;

  // Encode one value/care bit into a cell pair
  function automatic cell_pair_e encode_cell(input logic val, input logic care);
    if (!care)    return CELL_WILD;
    else if (val) return CELL_ONE;
    else          return CELL_ZERO;
  endfunction

endpackage

// File: rtl/tcam_row.sv
module tcam_row
  import tcam_pkg::*;
#(
  parameter int KEY_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             wr_raw,
  input  logic [KEY_W-1:0] wr_val,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [KEY_W-1:0] key,
  output logic             match
);

  logic [KEY_W-1:0] plane_hi;
  logic [KEY_W-1:0] plane_lo;
  logic [KEY_W-1:0] new_hi;
  logic [KEY_W-1:0] new_lo;
  logic [KEY_W-1:0] bit_miss;
  logic             written;

  // Per-position pair conversion
  always_comb begin
    for (int b = 0; b < KEY_W; b++) begin
      cell_pair_e p;
      p = encode_cell(wr_val[b], wr_care[b]);
      new_hi[b] = wr_raw ? wr_val[b]  : p[1];
      new_lo[b] = wr_raw ? wr_care[b] : p[0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_sel) begin
      plane_hi <= new_hi;
      plane_lo <= new_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      written <= 1'b0;
    else if (wr_sel) written <= 1'b1;
  end

  // High plane forbids key 0, low plane forbids key 1; 1/1 forbids both
  assign bit_miss = (plane_hi & ~key) | (plane_lo & key);
  assign match    = written && (bit_miss == '0);

  // R1: a normal write never leaves a 1/1 pair
  a_r1_no_never_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_raw) |=> ((plane_hi & plane_lo) == '0));

  // R2: a raw write lands unchanged in the planes
  a_r2_raw_planes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_raw) |=> (plane_hi == $past(wr_val) && plane_lo == $past(wr_care)));

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N  = 512,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);

  // Scan from the top so the lowest set bit wins
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcam_scan.sv
module tcam_scan #(
  parameter int KEY_W = 18,
  parameter int CAP_W = 522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             capture,
  input  logic             si,
  input  logic [CAP_W-1:0] cap_data,
  output logic [KEY_W-1:0] key_q,
  output logic             so
);

  logic [CAP_W-1:0] out_chain;

  always_ff @(posedge clk) begin
    if (!rst_n)     key_q <= '0;
    else if (shift) key_q <= {key_q[KEY_W-2:0], si};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       out_chain <= '0;
    else if (capture) out_chain <= cap_data;
    else if (shift)   out_chain <= {out_chain[CAP_W-2:0], 1'b0};
  end

  assign so = out_chain[CAP_W-1];

  // R10: shift enters at bit 0
  a_r10_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (key_q[0] == $past(si)));

  // R11: capture presents the hit flag first
  a_r11_capture_head: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (so == $past(cap_data[CAP_W-1])));

endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int ROWS  = 512,
  parameter int KEY_W = 18,
  parameter int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_raw,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [KEY_W-1:0] wr_val,
  input  logic [KEY_W-1:0] wr_care,
  input  logic             srch_valid,
  output logic             srch_ready,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ROWS-1:0]  res_match,
  output logic [IDX_W-1:0] res_idx,
  output logic             res_hit,
  input  logic             pdn,
  input  logic             tst_mode,
  input  logic             tst_shift,
  input  logic             tst_capture,
  input  logic             tst_si,
  output logic             tst_so
);

  localparam int CAP_W = ROWS + IDX_W + 1;

  logic [KEY_W-1:0] scan_key;
  logic [KEY_W-1:0] key_used;
  logic [ROWS-1:0]  row_match;
  logic [ROWS-1:0]  r_match;
  logic             acc;

  assign key_used   = tst_mode ? scan_key : srch_key;
  assign srch_ready = !res_valid || res_ready;
  assign acc        = srch_valid && srch_ready;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    tcam_row #(.KEY_W(KEY_W)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (wr_en && (wr_addr == IDX_W'(g))),
      .wr_raw (wr_raw),
      .wr_val (wr_val),
      .wr_care(wr_care),
      .key    (key_used),
      .match  (row_match[g])
    );
  end

  // Result register: captures rows before any same-edge write lands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      r_match   <= '0;
    end else begin
      if (acc) begin
        res_valid <= 1'b1;
        r_match   <= pdn ? '0 : row_match;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign res_match = r_match;

  tcam_prio #(.N(ROWS), .IW(IDX_W)) u_prio (
    .vec(r_match),
    .idx(res_idx),
    .any(res_hit)
  );

  tcam_scan #(.KEY_W(KEY_W), .CAP_W(CAP_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (tst_shift),
    .capture (tst_capture),
    .si      (tst_si),
    .cap_data({res_hit, res_idx, res_match}),
    .key_q   (scan_key),
    .so      (tst_so)
  );

  // R3: accepted search yields a result next cycle
  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  // R4: hit flag agrees with the match vector
  a_r4_hit_any: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit == (res_match != '0));

  // R5: index points at a set bit with nothing set below it
  a_r5_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_match[res_idx] &&
      ((res_match & (({{(ROWS-1){1'b0}}, 1'b1} << res_idx) - 1'b1)) == '0)));

  // R6: no hit from a search accepted in power-down
  a_r6_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pdn) |=> (!res_hit && res_idx == '0));

  // R9: a stalled result is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_match)));

endmodule

// File: tb/sim_tcam_array.sv
`timescale 1ns/1ps
module sim_tcam_array;

  localparam int ROWS  = 512;
  localparam int KEY_W = 18;
  localparam int IDX_W = 9;
  localparam int CAP_W = ROWS + IDX_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_raw = 0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [KEY_W-1:0] wr_val = '0, wr_care = '0, srch_key = '0;
  logic srch_valid = 0, res_ready = 1, pdn = 0;
  logic tst_mode = 0, tst_shift = 0, tst_capture = 0, tst_si = 0;
  logic srch_ready, res_valid, res_hit, tst_so;
  logic [ROWS-1:0]  res_match;
  logic [IDX_W-1:0] res_idx;

  always #5 clk = ~clk;

  tcam_array #(.ROWS(ROWS), .KEY_W(KEY_W), .IDX_W(IDX_W)) u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model of the stored pairs
  logic [KEY_W-1:0] m_hi [ROWS];
  logic [KEY_W-1:0] m_lo [ROWS];
  bit               m_vld[ROWS];
  logic [KEY_W-1:0] m_scan_key = '0;

  // Scoreboard
  logic [ROWS-1:0]  q_m[$];
  logic [IDX_W-1:0] q_i[$];
  bit               q_h[$];
  string            q_t[$];

  function automatic logic [ROWS-1:0] model_match(input logic [KEY_W-1:0] k);
    logic [ROWS-1:0] v;
    for (int r = 0; r < ROWS; r++) begin
      bit ok;
      ok = m_vld[r];
      for (int b = 0; b < KEY_W; b++) begin
        case ({m_hi[r][b], m_lo[r][b]})
          2'b10:   if (k[b] != 1'b1) ok = 0;
          2'b01:   if (k[b] != 1'b0) ok = 0;
          2'b11:   ok = 0;
          default: ;
        endcase
      end
      v[r] = ok;
    end
    return v;
  endfunction

  function automatic logic [IDX_W-1:0] lowest(input logic [ROWS-1:0] v);
    for (int r = 0; r < ROWS; r++) if (v[r]) return IDX_W'(r);
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_expect(input logic [KEY_W-1:0] k, input string tag);
    logic [ROWS-1:0] v;
    v = pdn ? '0 : model_match(tst_mode ? m_scan_key : k);
    q_m.push_back(v);
    q_i.push_back(lowest(v));
    q_h.push_back(v != '0);
    q_t.push_back(tag);
  endtask

  task automatic model_write(input logic [IDX_W-1:0] a, input bit raw,
                             input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
    m_vld[a] = 1;
    if (raw) begin
      m_hi[a] = v; m_lo[a] = c;
    end else begin
      m_hi[a] = v & c; m_lo[a] = ~v & c;
    end
  endtask

  task automatic do_write(input logic [IDX_W-1:0] a, input bit raw,
                          input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] c);
    @(negedge clk); #1;
    wr_en = 1; wr_raw = raw; wr_addr = a; wr_val = v; wr_care = c;
    @(posedge clk);
    model_write(a, raw, v, c);
    @(negedge clk); #1;
    wr_en = 0; wr_raw = 0;
  endtask

  task automatic do_search(input logic [KEY_W-1:0] k, input string tag);
    @(negedge clk); #1;
    srch_valid = 1; srch_key = k;
    while (!srch_ready) begin @(negedge clk); #1; end
    push_expect(k, tag);
    @(posedge clk);
    @(negedge clk); #1;
    srch_valid = 0;
  endtask

  // Monitor: pop on every result transfer
  always @(posedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (q_m.size() == 0) begin
        check(0, "R3 unexpected result", 64'(res_hit), 0);
      end else begin
        logic [ROWS-1:0] em; logic [IDX_W-1:0] ei; bit eh; string t;
        em = q_m.pop_front(); ei = q_i.pop_front(); eh = q_h.pop_front(); t = q_t.pop_front();
        n_tests++;
        if (res_match !== em || res_idx !== ei || res_hit !== eh) begin
          n_fail++;
          $display("FAIL %s actual match=%h idx=%0d hit=%0d expected match=%h idx=%0d hit=%0d",
                   t, res_match, res_idx, res_hit, em, ei, eh);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [ROWS-1:0] snap;
    logic [CAP_W-1:0] exp_cap;
    logic [KEY_W-1:0] sk;
    int bad;
    for (int r = 0; r < ROWS; r++) begin m_hi[r] = '0; m_lo[r] = '0; m_vld[r] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;
    @(negedge clk);
    check(res_valid == 0, "R12 res_valid after reset", 64'(res_valid), 0);
    check(srch_ready == 1, "R12 srch_ready after reset", 64'(srch_ready), 1);

    // R7: nothing written, nothing matches
    do_search(18'h00000, "R7 empty array key 0");
    do_search(18'h3FFFF, "R7 empty array key ones");

    // R1: exact row, wildcard row, partial-care row
    do_write(9'd5, 0, 18'h2A5A3, 18'h3FFFF);
    do_write(9'd9, 0, 18'h00000, 18'h00000);
    do_write(9'd3, 0, 18'h2A000, 18'h3F000);
    do_search(18'h2A5A3, "R1 R3 exact, partial, wildcard rows");
    do_search(18'h2AFFF, "R1 R5 partial care row lowest");
    do_search(18'h15A5C, "R1 R4 only wildcard row");

    // R2: 1/1 at bit 0 fences the wildcard row
    do_write(9'd9, 1, 18'h00001, 18'h00001);
    do_search(18'h2A5A3, "R2 never pair row drops out");
    do_search(18'h15A5C, "R2 R5 no match gives idx 0");
    do_search(18'h15A5D, "R2 never pair key bit 1");

    // R5: high rows
    do_write(9'd511, 0, 18'h1234F, 18'h3FFFF);
    do_write(9'd400, 0, 18'h1234F, 18'h3FFF0);
    do_search(18'h12340, "R5 row 400 only");
    do_search(18'h1234F, "R5 lowest of 400 and 511");

    // R6: power-down
    @(negedge clk); #1; pdn = 1;
    do_search(18'h1234F, "R6 search in power-down");
    do_write(9'd200, 0, 18'h0BEEF, 18'h3FFFF);
    do_search(18'h0BEEF, "R6 write during power-down, search off");
    repeat (2) @(negedge clk); #1; pdn = 0;
    do_search(18'h1234F, "R6 contents kept after power-down");
    do_search(18'h0BEEF, "R6 row written in power-down");

    // R8: same-edge write and search on row 400
    @(negedge clk); #1;
    wr_en = 1; wr_addr = 9'd400; wr_val = 18'h00077; wr_care = 18'h3FFFF;
    srch_valid = 1; srch_key = 18'h12341;
    push_expect(18'h12341, "R8 same-edge sees old row");
    @(posedge clk);
    model_write(9'd400, 0, 18'h00077, 18'h3FFFF);
    @(negedge clk); #1; wr_en = 0; srch_valid = 0;
    do_search(18'h12341, "R8 next search sees new row");
    do_search(18'h00077, "R8 new row value");

    // R9: back-pressure
    @(negedge clk); #1; res_ready = 0;
    do_search(18'h1234F, "R9 first search under stall");
    srch_valid = 1; srch_key = 18'h2A5A3;
    check(srch_ready == 0, "R9 ready low while result held", 64'(srch_ready), 0);
    snap = res_match;
    repeat (3) @(negedge clk);
    check(res_valid == 1 && res_match == snap, "R9 result held stable", 64'(res_match[63:0]), 64'(snap[63:0]));
    check(srch_ready == 0, "R9 second search still waits", 64'(srch_ready), 0);
    #1;
    push_expect(18'h2A5A3, "R9 second search after release");
    res_ready = 1;
    @(posedge clk);
    @(negedge clk); #1; srch_valid = 0;

    // R10 / R11: scan key in, result out
    @(negedge clk); #1; res_ready = 0; tst_mode = 1;
    sk = 18'h2AFFF;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      tst_shift = 1; tst_si = sk[i];
      @(negedge clk); #1;
    end
    tst_shift = 0;
    m_scan_key = sk;
    do_search(18'h00000, "R10 search uses scan key");
    exp_cap = {q_h[q_h.size()-1], q_i[q_i.size()-1], q_m[q_m.size()-1]};
    tst_capture = 1;
    @(negedge clk); #1; tst_capture = 0;
    bad = 0;
    for (int j = 0; j < CAP_W; j++) begin
      @(negedge clk);
      if (tst_so !== exp_cap[CAP_W-1-j]) bad++;
      #1; tst_shift = 1;
    end
    tst_shift = 0;
    check(bad == 0, "R11 scanned-out result bits", 64'(bad), 0);
    @(negedge clk); #1; tst_mode = 0; res_ready = 1;
    repeat (3) @(negedge clk);
    do_search(18'h2AFFF, "R10 functional key again");

    repeat (4) @(negedge clk);
    check(q_m.size() == 0, "R3 every search produced a result", 64'(q_m.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule